// File: doc/BRIEF.md
# USB Host Port Status and Wake Register Bank

This block holds one 32-bit status and control word for each downstream port of a USB 2.0 host controller. Software writes three wake enables and a four-bit port test-mode code into each word. The word also shows two live port conditions: whether a device is attached, and whether an over-current fault is present. When an enabled wake condition occurs on any port, the block raises one shared power-management-event flag. That flag stays set until software acknowledges it.

Each port tracks attachment with a two-state link machine. `LINK_DETACHED` moves to `LINK_ATTACHED` on the *attach* transition, when the connect input is high. `LINK_ATTACHED` moves back to `LINK_DETACHED` on the *detach* transition, when the connect input is low. The attach and detach transitions are the edges that the connect and disconnect wake enables watch. Over-current wake is level-sensitive instead. The shared flag is a second two-state machine. `PME_QUIET` moves to `PME_PENDING` on the *raise* transition, when any port reports an enabled wake event. `PME_PENDING` returns to `PME_QUIET` on the *acknowledge* transition, which is a clear pulse with no wake event in the same cycle.

The port words and the flag are reset only by the power-on reset and by the host controller reset. The ordinary system reset clears only the registered read-data path. Registers sit at consecutive 4-byte addresses from a base address. Each port also drives a test-active line and a one-hot decode of its test-mode code.

Top module: `usbp_port_bank`

## Requirements
- R1: After power-on reset, with the connect and over-current inputs low, every port word reads 0x00003000, test_active is 0 for every port, and pme_status is 0.
- R2: While bit 22 (over-current wake enable) is 1 and bit 4 (over-current active) reads 1, pme_status becomes 1. With bit 22 at 0, over-current leaves pme_status unchanged.
- R3: With bit 21 (disconnect wake enable) at 1, a change of bit 0 (connect status) from 1 to 0 sets pme_status in the clock edge where the link machine takes the detach transition.
- R4: With bit 20 (connect wake enable) at 1, a change of bit 0 from 0 to 1 sets pme_status in the clock edge where the link machine takes the attach transition. A detach does not set pme_status when only bit 20 is enabled.
- R5: pme_status is sticky. It clears only on a cycle where pme_clr is 1 and no enabled wake event is present. When a wake event and pme_clr fall in the same cycle, the flag stays set.
- R6: Bits 19:16 hold the test code and read back exactly as written, including the values 6 to 15. test_active for a port is 1 whenever its code is nonzero. For that port's test_sel slice, code 1 (J) gives bit 0, code 2 (K) gives bit 1, code 3 (SE0_NAK) gives bit 2, code 4 (test packet) gives bit 3, and code 5 (force enable) gives bit 4. Codes 0 and 6 to 15 give a zero slice.
- R7: Writes to bits 31:23 and 15:0 have no effect. Bits 31:23 always read 0, and bits 13:12 always read 1.
- R8: Bit 0 and bit 4 follow the port's connect and over-current inputs one clock edge after the inputs change.
- R9: A low por_n, or a clock edge with hc_reset high, returns every port word to 0x00003000 (with inputs low) and clears pme_status. A low sys_rst_n leaves the port words and pme_status unchanged.
- R10: Port p answers only at byte address BASE_ADDR + 4·p. A write to any other address, whether misaligned or beyond the last port, changes no port word, and a read from such an address returns 0.
- R11: bus_rdata is registered. It takes the addressed word at the clock edge where bus_rd is 1, holds its value while bus_rd is 0, and is 0 while sys_rst_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| sys_rst_n | input | 1 | System reset, active low; clears only the read-data register |
| hc_reset | input | 1 | Host controller reset, active high, synchronous |
| bus_addr | input | ADDR_W | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| port_connect | input | NPORTS | Per-port device attached input |
| port_overcur | input | NPORTS | Per-port over-current input |
| pme_clr | input | 1 | Acknowledge pulse for the wake flag |
| pme_status | output | 1 | Sticky power-management-event flag |
| test_active | output | NPORTS | Per-port test code is nonzero |
| test_sel | output | NPORTS*MODE_N | Per-port one-hot test-mode decode |

## Verification
Suppose a link machine held the wrong state. Bit 0 of that port's word would read wrong on the very next read. A missed or duplicated attach or detach transition would also show on pme_status one edge after the connect input changes. A wake flag that dropped without an acknowledge, or that could not be acknowledged, shows on pme_status within a cycle. The tests therefore sample pme_status at the exact edge where it must change, and again after it should have held. Corrupted control bits show on the test decode outputs immediately and on readback one cycle after the read strobe.

// File: rtl/usbp_pkg.sv
package usbp_pkg;

    localparam int REG_W  = 32;
    localparam int TEST_W = 4;

    // bit positions a reader of the word depends on
    localparam int BIT_CONN = 0;
    localparam int BIT_OC   = 4;
    localparam int CTL_LO   = 16;
    localparam int CTL_HI   = 22;

    // bits that read as one after reset and never change
    localparam logic [REG_W-1:0] FIXED_ONES = 32'h0000_3000;

    typedef enum logic {
        LINK_DETACHED,
        LINK_ATTACHED
    } link_state_t;

    typedef enum logic {
        PME_QUIET,
        PME_PENDING
    } pme_state_t;

    // control field, bits 22:16 of the port word
    typedef struct packed {
        logic              wake_oc;
        logic              wake_detach;
        logic              wake_attach;
        logic [TEST_W-1:0] test_code;
    } port_ctl_t;

endpackage

// File: rtl/usbp_link_fsm.sv
module usbp_link_fsm
    import usbp_pkg::*;
(
    input  logic clk,
    input  logic por_n,
    input  logic hc_reset,
    input  logic conn_in,
    output logic attached,
    output logic evt_attach,
    output logic evt_detach
);

    link_state_t state_q;
    link_state_t state_d;

    // state register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= LINK_DETACHED;
        end else if (hc_reset) begin
            state_q <= LINK_DETACHED;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and transition outputs
    always_comb begin
        state_d    = state_q;
        evt_attach = 1'b0;
        evt_detach = 1'b0;
        unique case (state_q)
            LINK_DETACHED: begin
                if (conn_in) begin
                    state_d    = LINK_ATTACHED;
                    evt_attach = 1'b1;
                end
            end
            LINK_ATTACHED: begin
                if (!conn_in) begin
                    state_d    = LINK_DETACHED;
                    evt_detach = 1'b1;
                end
            end
            default: state_d = LINK_DETACHED;
        endcase
    end

    always_comb begin
        attached = (state_q == LINK_ATTACHED);
    end

endmodule

// File: rtl/usbp_test_decode.sv
module usbp_test_decode
    import usbp_pkg::*;
#(
    parameter int MODE_N = 5
) (
    input  logic [TEST_W-1:0] code,
    output logic              active,
    output logic [MODE_N-1:0] sel
);

    assign active = |code;

    // code m+1 selects line m; codes above MODE_N select nothing
    for (genvar m = 0; m < MODE_N; m++) begin : g_mode
        assign sel[m] = (code == TEST_W'(m + 1));
    end

endmodule

// File: rtl/usbp_port_reg.sv
module usbp_port_reg
    import usbp_pkg::*;
#(
    parameter int MODE_N = 5
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              hc_reset,
    input  logic              wr_en,
    input  port_ctl_t         ctl_wdata,
    input  logic              conn_in,
    input  logic              oc_in,
    output logic [REG_W-1:0]  rd_value,
    output logic              wake_evt,
    output logic              test_active,
    output logic [MODE_N-1:0] test_sel
);

    port_ctl_t ctl_q;
    logic      oc_q;
    logic      attached;
    logic      evt_attach;
    logic      evt_detach;

    usbp_link_fsm u_link (
        .clk        (clk),
        .por_n      (por_n),
        .hc_reset   (hc_reset),
        .conn_in    (conn_in),
        .attached   (attached),
        .evt_attach (evt_attach),
        .evt_detach (evt_detach)
    );

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            ctl_q <= '0;
            oc_q  <= 1'b0;
        end else if (hc_reset) begin
            ctl_q <= '0;
            oc_q  <= 1'b0;
        end else begin
            oc_q <= oc_in;
            if (wr_en) begin
                ctl_q <= ctl_wdata;
            end
        end
    end

    always_comb begin
        wake_evt = (ctl_q.wake_oc     & oc_q)
                 | (ctl_q.wake_attach & evt_attach)
                 | (ctl_q.wake_detach & evt_detach);
    end

    always_comb begin
        rd_value                 = FIXED_ONES;
        rd_value[BIT_CONN]       = attached;
        rd_value[BIT_OC]         = oc_q;
        rd_value[CTL_HI:CTL_LO]  = ctl_q;
    end

    usbp_test_decode #(.MODE_N(MODE_N)) u_dec (
        .code   (ctl_q.test_code),
        .active (test_active),
        .sel    (test_sel)
    );

endmodule

// File: rtl/usbp_pme_flag.sv
module usbp_pme_flag
    import usbp_pkg::*;
(
    input  logic clk,
    input  logic por_n,
    input  logic hc_reset,
    input  logic set_any,
    input  logic clr,
    output logic pme
);

    pme_state_t state_q;
    pme_state_t state_d;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= PME_QUIET;
        end else if (hc_reset) begin
            state_q <= PME_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    // a new event outranks the acknowledge
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PME_QUIET: begin
                if (set_any) state_d = PME_PENDING;
            end
            PME_PENDING: begin
                if (clr && !set_any) state_d = PME_QUIET;
            end
            default: state_d = PME_QUIET;
        endcase
    end

    always_comb begin
        pme = (state_q == PME_PENDING);
    end

endmodule

// File: rtl/usbp_port_bank.sv
module usbp_port_bank
    import usbp_pkg::*;
#(
    parameter int NPORTS    = 6,
    parameter int ADDR_W    = 8,
    parameter int BASE_ADDR = 'h44,
    parameter int MODE_N    = 5
) (
    input  logic                       clk,
    input  logic                       por_n,
    input  logic                       sys_rst_n,
    input  logic                       hc_reset,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic                       bus_wr,
    input  logic                       bus_rd,
    input  logic [REG_W-1:0]           bus_wdata,
    output logic [REG_W-1:0]           bus_rdata,
    input  logic [NPORTS-1:0]          port_connect,
    input  logic [NPORTS-1:0]          port_overcur,
    input  logic                       pme_clr,
    output logic                       pme_status,
    output logic [NPORTS-1:0]          test_active,
    output logic [NPORTS*MODE_N-1:0]   test_sel
);

    localparam int STRIDE = 4;

    logic [NPORTS-1:0] hit;
    logic [NPORTS-1:0] wake_vec;
    logic [REG_W-1:0]  rd_val [NPORTS];
    logic [REG_W-1:0]  rd_mux;
    logic [REG_W-1:0]  rdata_q;
    port_ctl_t         ctl_wdata;
    logic              wdata_unused;

    assign ctl_wdata    = bus_wdata[CTL_HI:CTL_LO];
    assign wdata_unused = ^{bus_wdata[REG_W-1:CTL_HI+1], bus_wdata[CTL_LO-1:0]};

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        localparam logic [ADDR_W-1:0] SLOT_ADDR = ADDR_W'(BASE_ADDR + STRIDE * p);

        assign hit[p] = (bus_addr == SLOT_ADDR);

        usbp_port_reg #(.MODE_N(MODE_N)) u_reg (
            .clk         (clk),
            .por_n       (por_n),
            .hc_reset    (hc_reset),
            .wr_en       (bus_wr & hit[p]),
            .ctl_wdata   (ctl_wdata),
            .conn_in     (port_connect[p]),
            .oc_in       (port_overcur[p]),
            .rd_value    (rd_val[p]),
            .wake_evt    (wake_vec[p]),
            .test_active (test_active[p]),
            .test_sel    (test_sel[p*MODE_N +: MODE_N])
        );
    end

    always_comb begin
        rd_mux = '0;
        for (int p = 0; p < NPORTS; p++) begin
            if (hit[p]) rd_mux = rd_val[p];
        end
    end

    always_ff @(posedge clk or negedge sys_rst_n) begin
        if (!sys_rst_n) begin
            rdata_q <= '0;
        end else if (bus_rd) begin
            rdata_q <= rd_mux;
        end
    end

    assign bus_rdata = rdata_q;

    usbp_pme_flag u_pme (
        .clk      (clk),
        .por_n    (por_n),
        .hc_reset (hc_reset),
        .set_any  (|wake_vec),
        .clr      (pme_clr),
        .pme      (pme_status)
    );

endmodule

// File: rtl/usbp_port_bank_chk.sv
module usbp_port_bank_chk #(
    parameter int NPORTS = 6,
    parameter int MODE_N = 5
) (
    input logic                     clk,
    input logic                     por_n,
    input logic                     sys_rst_n,
    input logic                     hc_reset,
    input logic                     bus_rd,
    input logic [31:0]              bus_rdata,
    input logic                     pme_clr,
    input logic                     pme_status,
    input logic [NPORTS-1:0]        test_active,
    input logic [NPORTS*MODE_N-1:0] test_sel
);

    AST_RSV_READ_ZERO: assert property (@(posedge clk) disable iff (!sys_rst_n)
        bus_rdata[31:23] == 9'd0); // R7

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!sys_rst_n)
        !bus_rd |=> $stable(bus_rdata)); // R11

    AST_PME_STICKY: assert property (@(posedge clk) disable iff (!por_n)
        (pme_status && !pme_clr && !hc_reset) |=> pme_status); // R5

    AST_HC_RESET_CLEARS: assert property (@(posedge clk) disable iff (!por_n)
        hc_reset |=> !pme_status); // R9

    for (genvar p = 0; p < NPORTS; p++) begin : g_chk
        AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!por_n)
            $onehot0(test_sel[p*MODE_N +: MODE_N])); // R6

        AST_SEL_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (!por_n)
            (|test_sel[p*MODE_N +: MODE_N]) |-> test_active[p]); // R6
    end

endmodule

bind usbp_port_bank usbp_port_bank_chk #(.NPORTS(NPORTS), .MODE_N(MODE_N)) u_chk (
    .clk         (clk),
    .por_n       (por_n),
    .sys_rst_n   (sys_rst_n),
    .hc_reset    (hc_reset),
    .bus_rd      (bus_rd),
    .bus_rdata   (bus_rdata),
    .pme_clr     (pme_clr),
    .pme_status  (pme_status),
    .test_active (test_active),
    .test_sel    (test_sel)
);

// File: tb/usbp_port_bank_test.sv
module usbp_port_bank_test;

    localparam int NP   = 6;
    localparam int AW   = 8;
    localparam int BASE = 'h44;
    localparam int MN   = 5;

    logic              clk = 1'b0;
    logic              por_n = 1'b0;
    logic              sys_rst_n = 1'b0;
    logic              hc_reset = 1'b0;
    logic [AW-1:0]     bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NP-1:0]     port_connect = '0;
    logic [NP-1:0]     port_overcur = '0;
    logic              pme_clr = 1'b0;
    logic              pme_status;
    logic [NP-1:0]     test_active;
    logic [NP*MN-1:0]  test_sel;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    usbp_port_bank #(.NPORTS(NP), .ADDR_W(AW), .BASE_ADDR(BASE), .MODE_N(MN)) uut (
        .clk          (clk),
        .por_n        (por_n),
        .sys_rst_n    (sys_rst_n),
        .hc_reset     (hc_reset),
        .bus_addr     (bus_addr),
        .bus_wr       (bus_wr),
        .bus_rd       (bus_rd),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .port_connect (port_connect),
        .port_overcur (port_overcur),
        .pme_clr      (pme_clr),
        .pme_status   (pme_status),
        .test_active  (test_active),
        .test_sel     (test_sel)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_addr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_addr(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    function automatic logic [AW-1:0] slot(input int p);
        return AW'(BASE + 4 * p);
    endfunction

    task automatic pulse_clr();
        @(negedge clk); pme_clr = 1'b1;
        @(negedge clk); pme_clr = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int p = 0; p < NP; p++) begin
            rd_addr(slot(p), v);
            check("R1 reset word", v, 32'h0000_3000);
        end
        check("R1 test_active", 32'(test_active), 32'h0);
        check("R1 pme", 32'(pme_status), 32'h0);
    endtask

    task automatic t_reserved_bits();
        logic [31:0] v;
        wr_addr(slot(2), 32'hFFFF_FFFF);
        rd_addr(slot(2), v);
        check("R7 reserved ignored", v, 32'h007F_3000);
        wr_addr(slot(2), 32'h0);
        rd_addr(slot(2), v);
        check("R7 cleared back", v, 32'h0000_3000);
    endtask

    task automatic t_test_decode();
        logic [31:0] v;
        logic [MN-1:0] exp_sel;
        for (int c = 0; c < 16; c++) begin
            wr_addr(slot(1), 32'(c) << 16);
            rd_addr(slot(1), v);
            check("R6 code readback", 32'(v[19:16]), 32'(c));
            check("R6 active", 32'(test_active[1]), 32'(c != 0));
            exp_sel = (c >= 1 && c <= MN) ? MN'(1 << (c - 1)) : '0;
            check("R6 sel", 32'(test_sel[1*MN +: MN]), 32'(exp_sel));
        end
        wr_addr(slot(1), 32'h0);
    endtask

    task automatic t_status_bits();
        logic [31:0] v;
        @(negedge clk);
        port_connect[3] = 1'b1; port_overcur[3] = 1'b1;
        @(negedge clk);
        rd_addr(slot(3), v);
        check("R8 conn and oc bits", v, 32'h0000_3011);
        check("R2 oc with wake disabled", 32'(pme_status), 32'h0);
        @(negedge clk);
        port_connect[3] = 1'b0; port_overcur[3] = 1'b0;
        @(negedge clk);
        rd_addr(slot(3), v);
        check("R8 bits fall", v, 32'h0000_3000);
        check("R2 still quiet", 32'(pme_status), 32'h0);
    endtask

    task automatic t_attach_wake();
        wr_addr(slot(0), 32'h0010_0000);
        @(negedge clk);
        port_connect[0] = 1'b1;
        @(negedge clk);
        check("R4 attach sets pme", 32'(pme_status), 32'h1);
        pulse_clr();
        check("R5 clear", 32'(pme_status), 32'h0);
        port_connect[0] = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R4 detach ignored", 32'(pme_status), 32'h0);
        wr_addr(slot(0), 32'h0);
    endtask

    task automatic t_detach_wake();
        @(negedge clk);
        port_connect[4] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R3 attach ignored", 32'(pme_status), 32'h0);
        wr_addr(slot(4), 32'h0020_0000);
        port_connect[4] = 1'b0;
        @(negedge clk);
        check("R3 detach sets pme", 32'(pme_status), 32'h1);
        pulse_clr();
        check("R3 cleared", 32'(pme_status), 32'h0);
        wr_addr(slot(4), 32'h0);
    endtask

    task automatic t_oc_wake();
        wr_addr(slot(5), 32'h0040_0000);
        port_overcur[5] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R2 oc sets pme", 32'(pme_status), 32'h1);
        pulse_clr();
        check("R5 event beats clear", 32'(pme_status), 32'h1);
        port_overcur[5] = 1'b0;
        repeat (3) @(negedge clk);
        check("R5 sticky", 32'(pme_status), 32'h1);
        pulse_clr();
        check("R5 acknowledged", 32'(pme_status), 32'h0);
        repeat (3) @(negedge clk);
        check("R5 stays clear", 32'(pme_status), 32'h0);
        wr_addr(slot(5), 32'h0);
    endtask

    task automatic t_addr_decode();
        logic [31:0] v;
        wr_addr(slot(NP), 32'h0070_0000);
        wr_addr(AW'(BASE + 1), 32'h0070_0000);
        for (int p = 0; p < NP; p++) begin
            rd_addr(slot(p), v);
            check("R10 stray write", v, 32'h0000_3000);
        end
        rd_addr(slot(NP), v);
        check("R10 out of range read", v, 32'h0);
        rd_addr(AW'(BASE + 2), v);
        check("R10 misaligned read", v, 32'h0);
    endtask

    task automatic t_resets();
        logic [31:0] v;
        wr_addr(slot(1), 32'h0043_0000);
        rd_addr(slot(1), v);
        @(negedge clk); sys_rst_n = 1'b0;
        @(negedge clk);
        check("R11 sys reset clears rdata", bus_rdata, 32'h0);
        sys_rst_n = 1'b1;
        rd_addr(slot(1), v);
        check("R9 sys reset keeps word", v, 32'h0043_3000);
        @(negedge clk); bus_addr = slot(2);
        repeat (3) @(negedge clk);
        check("R11 rdata held", bus_rdata, 32'h0043_3000);
        @(negedge clk); hc_reset = 1'b1;
        @(negedge clk); hc_reset = 1'b0;
        rd_addr(slot(1), v);
        check("R9 hc reset", v, 32'h0000_3000);
        wr_addr(slot(1), 32'h0013_0000);
        @(negedge clk); por_n = 1'b0;
        @(negedge clk); por_n = 1'b1;
        rd_addr(slot(1), v);
        check("R9 power-on reset", v, 32'h0000_3000);
        check("R9 test_active after por", 32'(test_active), 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        por_n = 1'b1; sys_rst_n = 1'b1;
        t_reset();
        t_reserved_bits();
        t_test_decode();
        t_status_bits();
        t_attach_wake();
        t_detach_wake();
        t_oc_wake();
        t_addr_decode();
        t_resets();
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule